// File: doc/BRIEF.md
# Period-Synchronous PWM Generator with Thermal and Loop-Alive Guards

This block is a single-channel pulse-width modulator for a switching power stage. The tracking controller commands the duty. It writes a compare value with a one-cycle strobe, and the block holds that value in a shadow register. The value moves into the active compare register only when one period ends and the next begins. A change of command therefore never cuts a pulse short or stretches it. Before a commanded value becomes active, it is limited to a configurable band.

Two protective paths can override the commanded duty. The first is a thermal throttle, driven by a temperature word and decided at each period boundary. While it is engaged, it caps the duty at an emergency level. It engages above a trip limit and releases only once the temperature has fallen below the trip limit minus a hysteresis value supplied at a port. The second is a loop-alive watchdog. If the controller stops writing duty values for a configured number of clock ticks, the output is forced low. It stays low until a reset or an explicit clear.

Three status outputs report the throttle state, the watchdog state and whether the value last made active had to be clamped. A one-cycle marker shows the first cycle of every period.

Top module: `guarded_pwm`

## Requirements
- R1: A duty write takes effect at the first period boundary after the clock edge that samples it. The period that is running when the write arrives completes with its previous duty.
- R2: The active duty is the written value limited to the range [DUTY_MIN, DUTY_MAX]. A value below the range becomes DUTY_MIN and a value above it becomes DUTY_MAX.
- R3: `clamp_active` is updated at each period boundary. It is 1 when the shadow value loaded at that boundary lay outside [DUTY_MIN, DUTY_MAX], and 0 otherwise.
- R4: The throttle engages when `temp_in` is strictly greater than TRIP_TEMP at a period boundary. The period starting at that boundary then runs with duty min(clamped command, EMERG_DUTY), and `throttle_active` reads 1.
- R5: An engaged throttle releases only when `temp_in` is strictly less than TRIP_TEMP − `temp_hyst` at a period boundary. If `temp_hyst` ≥ TRIP_TEMP, the throttle never releases. The full commanded duty returns in the period starting at the boundary where it releases.
- R6: `throttle_active` changes only at period boundaries, whatever `temp_in` does in mid-period.
- R7: `wdog_tripped` rises exactly WDOG_TICKS clock edges after the last edge that sampled `duty_wr` high, provided no further write arrives. Each write restarts this count.
- R8: Once `wdog_tripped` is 1, `pwm_out` is 0 from the following cycle onward, whatever later duty writes arrive. The trip stays set until reset or `wdog_clr`.
- R9: A `wdog_clr` pulse clears the trip and restarts the watchdog count. The commanded duty returns at the next period boundary.
- R10: Reset gives `pwm_out`, `period_start`, `throttle_active`, `wdog_tripped` and `clamp_active` all 0. The first period after reset has zero duty, and later periods use DUTY_MIN until a write arrives.
- R11: Each period lasts PERIOD cycles. `period_start` is 1 in its first cycle only. `pwm_out` is 1 in the first D cycles of the period and 0 in the rest, where D is the active duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_wr | input | 1 | One-cycle strobe that writes `duty_in` into the shadow register |
| duty_in | input | DW | Commanded duty in counts (DW = clog2(PERIOD+1)) |
| temp_in | input | TEMP_W | Power-stage temperature in degrees |
| temp_hyst | input | TEMP_W | Release hysteresis below TRIP_TEMP |
| wdog_clr | input | 1 | Clears a watchdog trip and restarts its count |
| pwm_out | output | 1 | Registered PWM output |
| period_start | output | 1 | High in the first cycle of each period |
| throttle_active | output | 1 | Thermal throttle engaged |
| wdog_tripped | output | 1 | Loop-alive watchdog has expired |
| clamp_active | output | 1 | Active duty was limited to the band |

## Verification
The three boundary-timed results (a new duty, the throttle state and the clamp flag) appear in the period whose `period_start` follows the controlling boundary. The bench therefore aligns on `period_start`, sampled at the falling clock edge. After any write it discards the next period, which may have begun on the same edge as the write, and it compares the cycle-by-cycle waveform of the period after that. For the in-flight case it writes during a measured period, expects the old duty for the rest of that period and the new one in the next. The watchdog trip is checked for absence one edge before edge WDOG_TICKS after the write and for presence one edge after it, and the output masking is checked one cycle after the trip flag rises.

// File: rtl/guarded_pwm_pkg.sv
package guarded_pwm_pkg;

  // Source of the duty loaded at a period boundary.
  typedef enum logic [1:0] {
    SRC_OFF     = 2'd0,
    SRC_THERMAL = 2'd1,
    SRC_TRACK   = 2'd2
  } duty_src_e;

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  function automatic int unsigned limit_u(input int unsigned v, input int unsigned lo,
                                          input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/gpwm_shadow_clamp.sv
module gpwm_shadow_clamp #(
  parameter int DW       = 10,
  parameter int DUTY_MIN = 50,
  parameter int DUTY_MAX = 950
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] clamped,
  output logic          out_of_band
);
  localparam logic [DW-1:0] LO = DW'(DUTY_MIN);
  localparam logic [DW-1:0] HI = DW'(DUTY_MAX);

  logic [DW-1:0] shadow_q;

  // Reset to the floor of the band so an unwritten shadow is never flagged.
  always_ff @(posedge clk) begin
    if (rst)     shadow_q <= LO;
    else if (wr) shadow_q <= din;
  end

  always_comb begin
    out_of_band = (shadow_q < LO) || (shadow_q > HI);
    if (shadow_q < LO)      clamped = LO;
    else if (shadow_q > HI) clamped = HI;
    else                    clamped = shadow_q;
  end

  // R1: the shadow register takes a written value on the next edge.
  assert_shadow_write_R1: assert property (@(posedge clk) disable iff (rst)
    wr |=> (shadow_q == $past(din)));
endmodule

// File: rtl/gpwm_period_gen.sv
module gpwm_period_gen #(
  parameter int PERIOD = 1000,
  parameter int DW     = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] active_cmp,
  input  logic          kill,
  output logic          wrap,
  output logic          pwm_q,
  output logic          start_q
);
  localparam logic [DW-1:0] LAST = DW'(PERIOD - 1);

  logic [DW-1:0] cnt_q;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pwm_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= wrap ? '0 : cnt_q + DW'(1);
      pwm_q   <= (cnt_q < active_cmp) && !kill;
      start_q <= (cnt_q == '0);
    end
  end

  // R11: the start marker lasts one cycle.
  assert_single_start_R11: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  // R11: the counter never leaves its range.
  assert_count_range_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/gpwm_thermal_guard.sv
module gpwm_thermal_guard #(
  parameter int TEMP_W    = 8,
  parameter int TRIP_TEMP = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_boundary,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] hyst,
  output logic              throttle_q,
  output logic              throttle_next
);
  localparam int TW1 = TEMP_W + 1;
  localparam logic [TEMP_W-1:0] TRIP  = TEMP_W'(TRIP_TEMP);
  localparam logic [TW1-1:0]    TRIPX = TW1'(TRIP_TEMP);

  logic [TW1-1:0] release_lvl;
  logic           hot, cool;

  always_comb begin
    if ({1'b0, hyst} >= TRIPX) release_lvl = '0;
    else                       release_lvl = TRIPX - {1'b0, hyst};
    hot  = (temp > TRIP);
    cool = ({1'b0, temp} < release_lvl);
    throttle_next = throttle_q ? !cool : hot;
  end

  always_ff @(posedge clk) begin
    if (rst)              throttle_q <= 1'b0;
    else if (at_boundary) throttle_q <= throttle_next;
  end

  // R6: state moves only on a period boundary.
  assert_throttle_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    !at_boundary |=> $stable(throttle_q));

  // R4: engaging requires a temperature above the limit.
  assert_engage_needs_heat_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(throttle_q) |-> $past(temp > TRIP));
endmodule

// File: rtl/gpwm_loop_watchdog.sv
module gpwm_loop_watchdog #(
  parameter int WDOG_TICKS = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  input  logic clr,
  output logic trip_q
);
  localparam int WW = (WDOG_TICKS > 2) ? $clog2(WDOG_TICKS) : 1;
  localparam logic [WW-1:0] LAST = WW'(WDOG_TICKS - 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (kick) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      trip_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + WW'(1);
    end
  end

  // R8: a trip holds until cleared.
  assert_trip_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (trip_q && !clr) |=> trip_q);

  // R7: a trip never rises on the edge that samples a write.
  assert_trip_needs_silence_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_q) |-> !$past(kick));
endmodule

// File: rtl/guarded_pwm.sv
module guarded_pwm
  import guarded_pwm_pkg::*;
#(
  parameter int PERIOD     = 1000,
  parameter int DUTY_MIN   = 50,
  parameter int DUTY_MAX   = 950,
  parameter int EMERG_DUTY = 200,
  parameter int TEMP_W     = 8,
  parameter int TRIP_TEMP  = 100,
  parameter int WDOG_TICKS = 125_000_000,
  localparam int DW        = $clog2(PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              duty_wr,
  input  logic [DW-1:0]     duty_in,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic [TEMP_W-1:0] temp_hyst,
  input  logic              wdog_clr,
  output logic              pwm_out,
  output logic              period_start,
  output logic              throttle_active,
  output logic              wdog_tripped,
  output logic              clamp_active
);
  localparam int unsigned EMERG_C = limit_u(EMERG_DUTY, DUTY_MIN, DUTY_MAX);

  logic          wrap, trip, thr_q, thr_next, oob;
  logic [DW-1:0] clamped, next_duty, active_q;
  logic          clamp_q;
  duty_src_e     src;

  gpwm_shadow_clamp #(.DW(DW), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)) u_shadow (
    .clk(clk), .rst(rst), .wr(duty_wr), .din(duty_in),
    .clamped(clamped), .out_of_band(oob)
  );

  gpwm_thermal_guard #(.TEMP_W(TEMP_W), .TRIP_TEMP(TRIP_TEMP)) u_thermal (
    .clk(clk), .rst(rst), .at_boundary(wrap), .temp(temp_in), .hyst(temp_hyst),
    .throttle_q(thr_q), .throttle_next(thr_next)
  );

  gpwm_loop_watchdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
    .clk(clk), .rst(rst), .kick(duty_wr), .clr(wdog_clr), .trip_q(trip)
  );

  gpwm_period_gen #(.PERIOD(PERIOD), .DW(DW)) u_period (
    .clk(clk), .rst(rst), .active_cmp(active_q), .kill(trip),
    .wrap(wrap), .pwm_q(pwm_out), .start_q(period_start)
  );

  always_comb begin
    if (trip)          src = SRC_OFF;
    else if (thr_next) src = SRC_THERMAL;
    else               src = SRC_TRACK;
    case (src)
      SRC_OFF:     next_duty = '0;
      SRC_THERMAL: next_duty = DW'(min_u(int'(clamped), EMERG_C));
      default:     next_duty = clamped;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
      clamp_q  <= 1'b0;
    end else if (wrap) begin
      active_q <= next_duty;
      clamp_q  <= oob;
    end
  end

  assign throttle_active = thr_q;
  assign wdog_tripped    = trip;
  assign clamp_active    = clamp_q;

  // R1: the active compare changes only on a period boundary.
  assert_active_at_boundary_R1: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(active_q));

  // R2: the active compare is either off or inside the band.
  assert_active_in_band_R2: assert property (@(posedge clk) disable iff (rst)
    (active_q == '0) || ((active_q >= DW'(DUTY_MIN)) && (active_q <= DW'(DUTY_MAX))));

  // R3: the clamp flag moves only on a period boundary.
  assert_clamp_flag_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(clamp_q));

  // R4: while throttled and not tripped, duty stays at or under the emergency level.
  assert_throttle_cap_R4: assert property (@(posedge clk) disable iff (rst)
    (thr_q && !trip) |-> (active_q <= DW'(EMERG_C)));

  // R8: a tripped watchdog silences the output on the next cycle.
  assert_zero_when_tripped_R8: assert property (@(posedge clk) disable iff (rst)
    trip |=> !pwm_out);
endmodule

// File: tb/guarded_pwm_tb_top.sv
module guarded_pwm_tb_top;
  localparam int P     = 20;
  localparam int DMIN  = 2;
  localparam int DMAX  = 18;
  localparam int EMERG = 5;
  localparam int TRIP  = 100;
  localparam int WT    = 200;
  localparam int DW    = $clog2(P + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          duty_wr = 1'b0;
  logic [DW-1:0] duty_in = '0;
  logic [7:0]    temp_in = 8'd25;
  logic [7:0]    temp_hyst = 8'd10;
  logic          wdog_clr = 1'b0;
  logic          pwm_out, period_start, throttle_active, wdog_tripped, clamp_active;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  guarded_pwm #(
    .PERIOD(P), .DUTY_MIN(DMIN), .DUTY_MAX(DMAX), .EMERG_DUTY(EMERG),
    .TEMP_W(8), .TRIP_TEMP(TRIP), .WDOG_TICKS(WT)
  ) dut_i (
    .clk(clk), .rst(rst), .duty_wr(duty_wr), .duty_in(duty_in),
    .temp_in(temp_in), .temp_hyst(temp_hyst), .wdog_clr(wdog_clr),
    .pwm_out(pwm_out), .period_start(period_start),
    .throttle_active(throttle_active), .wdog_tripped(wdog_tripped),
    .clamp_active(clamp_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input int v);
    @(negedge clk);
    duty_in = DW'(v);
    duty_wr = 1'b1;
    @(negedge clk);
    duty_wr = 1'b0;
  endtask

  // Samples one full period from its start marker; optional write at offset 3.
  task automatic measure_raw(input bit wr_en, input int wr_val, input int exp,
                             output int hi, output int bad);
    while (period_start !== 1'b1) @(negedge clk);
    hi = 0;
    bad = 0;
    for (int i = 0; i < P; i++) begin
      if (wr_en && i == 3) begin duty_in = DW'(wr_val); duty_wr = 1'b1; end
      if (wr_en && i == 4) duty_wr = 1'b0;
      if (pwm_out !== (i < exp)) bad++;
      if (pwm_out === 1'b1) hi++;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int exp, input string req);
    int hi, bad;
    measure_raw(1'b0, 0, exp, hi, bad);
    check(bad == 0 && hi == exp, req, hi, exp);
  endtask

  task automatic settle(input int v);
    int hi, bad;
    kick(v);
    measure_raw(1'b0, 0, 0, hi, bad);
  endtask

  task automatic clear_wdog();
    @(negedge clk); wdog_clr = 1'b1;
    @(negedge clk); wdog_clr = 1'b0;
  endtask

  task automatic test_reset();
    repeat (4) @(negedge clk);
    check(pwm_out === 1'b0 && period_start === 1'b0, "R10 outputs in reset", pwm_out, 0);
    check(throttle_active === 1'b0 && wdog_tripped === 1'b0 && clamp_active === 1'b0,
          "R10 flags in reset", {throttle_active, wdog_tripped, clamp_active}, 0);
    rst = 1'b0;
    measure(0, "R10 first period zero duty");
    measure(DMIN, "R10 default band floor");
  endtask

  task automatic test_waveform();
    settle(7);
    measure(7, "R11 duty 7 waveform");
    settle(15);
    measure(15, "R11 duty 15 waveform");
  endtask

  task automatic test_shadow();
    int hi, bad;
    settle(7);
    measure_raw(1'b1, 12, 7, hi, bad);
    check(bad == 0 && hi == 7, "R1 in-flight period keeps old duty", hi, 7);
    measure(12, "R1 new duty next period");
  endtask

  task automatic test_clamp();
    settle(0);
    measure(DMIN, "R2 below band");
    check(clamp_active === 1'b1, "R3 flag below band", clamp_active, 1);
    settle(25);
    measure(DMAX, "R2 above band");
    check(clamp_active === 1'b1, "R3 flag above band", clamp_active, 1);
    settle(DMAX);
    measure(DMAX, "R2 band ceiling kept");
    check(clamp_active === 1'b0, "R3 flag in band", clamp_active, 0);
    settle(DMIN);
    measure(DMIN, "R2 band floor kept");
  endtask

  task automatic test_thermal();
    temp_hyst = 8'd10;
    temp_in = 8'd100;
    settle(12);
    measure(12, "R4 trip limit itself not hot");
    check(throttle_active === 1'b0, "R4 no throttle at limit", throttle_active, 0);
    while (period_start !== 1'b1) @(negedge clk);
    temp_in = 8'd101;
    repeat (3) @(negedge clk);
    check(throttle_active === 1'b0, "R6 no mid-period engage", throttle_active, 0);
    measure(EMERG, "R4 emergency duty");
    check(throttle_active === 1'b1, "R4 throttle flag", throttle_active, 1);
    settle(3);
    measure(3, "R4 lower command kept");
    temp_in = 8'd95;
    settle(12);
    measure(EMERG, "R5 held inside hysteresis");
    temp_in = 8'd90;
    settle(12);
    measure(EMERG, "R5 held at release edge");
    check(throttle_active === 1'b1, "R5 flag held", throttle_active, 1);
    temp_in = 8'd89;
    settle(12);
    measure(12, "R5 released duty");
    check(throttle_active === 1'b0, "R5 flag released", throttle_active, 0);
    temp_in = 8'd25;
  endtask

  task automatic test_watchdog();
    clear_wdog();
    kick(9);
    repeat (150) @(negedge clk);
    kick(9);
    repeat (150) @(negedge clk);
    check(wdog_tripped === 1'b0, "R7 write restarts count", wdog_tripped, 0);
    kick(10);
    repeat (WT - 1) @(posedge clk);
    @(negedge clk);
    check(wdog_tripped === 1'b0, "R7 not yet expired", wdog_tripped, 0);
    @(posedge clk);
    @(negedge clk);
    check(wdog_tripped === 1'b1, "R7 expired on time", wdog_tripped, 1);
    @(negedge clk);
    check(pwm_out === 1'b0, "R8 output low next cycle", pwm_out, 0);
    settle(10);
    measure(0, "R8 writes do not revive output");
    check(wdog_tripped === 1'b1, "R8 trip sticky", wdog_tripped, 1);
    clear_wdog();
    check(wdog_tripped === 1'b0, "R9 clear drops trip", wdog_tripped, 0);
    settle(10);
    measure(10, "R9 duty resumes");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_waveform();
    test_shadow();
    test_clamp();
    test_thermal();
    test_watchdog();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule